// File: doc/BRIEF.md
# Power-Rail Fault Supervisor

This block watches the fault flags of a set of supply rails and decides how the power sequencer must react to each one. A minor fault is an undervoltage on a rail that is up and regulating, or an overcurrent on the main memory rail (rail 0). It takes only the affected rail down, so that the sequencer can bring that rail back through its normal start-up order, and it adds one to a fault count. A serious event latches a global shutdown of every rail. Serious events are an overvoltage on the memory rail or on the termination rail, an over-temperature flag, or the fault count reaching its limit.

The fault count is forgiven after a quiet period. A free-running window counter advances on a slow tick enable and restarts at every new fault. When it completes its span with no further fault, the count returns to zero. The count limit is lower while the system is being brought up out of its deepest sleep state (input `cold_start` high). A downstream rail that loses its input because an upstream rail was disabled reports its own undervoltage, and that report is counted on its own.

The shutdown latch and all per-rail disables are released by a rising edge on the active-low deepest-sleep input `s5_n`, or by the synchronous reset (power-on reset). A thermal shutdown is released only if the cool flag is also high at that edge.

Top module: `fault_supervisor`

## Requirements
- R1: During and right after reset, `rail_dis`, `shutdown` and `fault_cnt` are all zero.
- R2: A rising edge of `uv[i]` while rail i is enabled, out of soft-start and not yet disabled sets `rail_dis[i]` at the next clock edge and adds one to `fault_cnt`. The bits of other rails are unchanged.
- R3: An undervoltage edge on a rail that is not enabled, that is in soft-start (`rail_ss[i]`=1), or that is already disabled changes neither `rail_dis` nor `fault_cnt`.
- R4: A fault flag held high counts once. It counts again only after it has dropped and risen again.
- R5: A rising edge of `oc_vddq` while rail 0 is enabled and not disabled sets `rail_dis[0]` and adds one to `fault_cnt`.
- R6: Undervoltage edges on several rails in the same cycle each add one to `fault_cnt` and each set their own disable bit.
- R7: `fault_cnt` returns to zero after WINDOW_TICKS tick cycles with no new fault, counted from the clock edge that recorded the last fault. A new fault restarts the span. If a fault falls on the expiring tick, the fault wins: the count goes up and does not clear.
- R8: `shutdown` is set at the edge where `fault_cnt` reaches COLD_LIMIT (4) while `cold_start` is 1, or WARM_LIMIT (5) otherwise. `fault_cnt` never exceeds WARM_LIMIT. While `shutdown` is 1, new faults neither count nor set disable bits.
- R9: `ov_vddq` or `ov_term` high sets `shutdown` at the next edge, whatever the count. While either flag is high, the latch stays set, even across an `s5_n` rising edge.
- R10: `ot_hot` high sets `shutdown`. An `s5_n` rising edge releases a thermal shutdown only when `ot_cool` is 1 at that edge.
- R11: An `s5_n` rising edge clears `fault_cnt` and every `rail_dis` bit. It also clears `shutdown` unless R9 or R10 hold it.
- R12: `retry_start[i]` high clears `rail_dis[i]` at the next edge and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on reset) |
| tick | input | 1 | Slow time-base enable that advances the forgiveness window |
| s5_n | input | 1 | Active-low deepest-sleep request; its rising edge clears the supervisor |
| cold_start | input | 1 | High while resuming from the deepest sleep state; selects the lower limit |
| rail_en | input | N_RAILS | Rail enabled by the sequencer |
| rail_ss | input | N_RAILS | Rail still in soft-start |
| uv | input | N_RAILS | Undervoltage comparator flags |
| oc_vddq | input | 1 | Overcurrent flag of rail 0 |
| ov_vddq | input | 1 | Overvoltage flag of rail 0 |
| ov_term | input | 1 | Overvoltage flag of the termination rail |
| ot_hot | input | 1 | Junction temperature above the trip level |
| ot_cool | input | 1 | Junction temperature below the release level |
| retry_start | input | N_RAILS | Sequencer restarts rail i; releases its disable |
| rail_dis | output | N_RAILS | Per-rail fault disable |
| shutdown | output | 1 | Global shutdown latch |
| fault_cnt | output | CNT_W | Current fault count |

## Verification
Two pairs of functions can land in the same cycle. The window can expire on the same tick that a new undervoltage edge arrives. The bench idles for exactly WINDOW_TICKS-1 ticks after a fault, checks that the count is still held, and then injects the next fault on the expiring tick. It expects the count to rise by one rather than clear. The second pair is an `s5_n` rising edge that arrives while an overvoltage flag is still high. The bench expects the latch to stay set while the count and the disables clear.

// File: rtl/fsup_pkg.sv
// Shared types for the rail fault supervisor.
package fsup_pkg;

    // Reason the global shutdown latch was set; decides how it may be released.
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_OVERVOLT = 2'd1,
        CAUSE_THERMAL  = 2'd2,
        CAUSE_LIMIT    = 2'd3
    } sd_cause_e;

endpackage

// File: rtl/fsup_event_qual.sv
// Fault event qualifier.
// Turns raw comparator levels into single-cycle fault events, one per rail.
// An undervoltage edge counts only while its rail is enabled, out of
// soft-start and not already disabled. An overcurrent edge folds into the
// event of rail 0.
// Assumes the flags are already synchronous to clk.
module fsup_event_qual #(
    parameter int N_RAILS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] uv,
    input  logic [N_RAILS-1:0] rail_en,
    input  logic [N_RAILS-1:0] rail_ss,
    input  logic [N_RAILS-1:0] rail_dis,
    input  logic               oc_vddq,
    output logic [N_RAILS-1:0] rail_evt
);

    logic [N_RAILS-1:0] uv_q;
    logic               oc_q;
    logic               oc_evt;

    // Remember last cycle's flag levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uv_q <= '0;
            oc_q <= 1'b0;
        end else begin
            uv_q <= uv;
            oc_q <= oc_vddq;
        end
    end

    // Overcurrent edge on rail 0 while that rail is live.
    always_comb begin
        oc_evt = oc_vddq & ~oc_q & rail_en[0] & ~rail_dis[0];
    end

    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        logic armed;
        assign armed = rail_en[g] & ~rail_ss[g] & ~rail_dis[g];
        if (g == 0) begin : g_main
            assign rail_evt[g] = (uv[g] & ~uv_q[g] & armed) | oc_evt;
        end else begin : g_other
            assign rail_evt[g] = uv[g] & ~uv_q[g] & armed;
        end
    end

endmodule

// File: rtl/fsup_fault_window.sv
// Fault counter with forgiveness window.
// Adds the number of events in a cycle to a saturating count. A window
// counter advances on tick while the count is non-zero and restarts on
// every event. When it completes WINDOW_TICKS ticks the count clears.
// limit_hit flags the cycle in which the count reaches the active limit.
// Assumes clear has priority over everything, and that freeze holds all state.
module fsup_fault_window #(
    parameter int N_RAILS      = 4,
    parameter int WINDOW_TICKS = 16384,
    parameter int COLD_LIMIT   = 4,
    parameter int WARM_LIMIT   = 5,
    localparam int CNT_W       = $clog2(WARM_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               clear,
    input  logic               freeze,
    input  logic               cold_start,
    input  logic [N_RAILS-1:0] evt,
    output logic [CNT_W-1:0]   fault_cnt,
    output logic               limit_hit
);

    localparam int WIN_W = $clog2(WINDOW_TICKS);
    localparam int EVT_W = $clog2(N_RAILS + 1);
    localparam int SUM_W = ((CNT_W > EVT_W) ? CNT_W : EVT_W) + 1;

    logic [WIN_W-1:0] win_cnt;
    logic [EVT_W-1:0] n_evt;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] limit;
    logic [CNT_W-1:0] cnt_sat;
    logic             win_last;

    // Count the events present this cycle.
    always_comb begin
        n_evt = '0;
        for (int i = 0; i < N_RAILS; i++) begin
            n_evt = n_evt + EVT_W'(evt[i]);
        end
    end

    // Saturating next count and limit comparison.
    always_comb begin
        sum       = SUM_W'(fault_cnt) + SUM_W'(n_evt);
        cnt_sat   = (sum > SUM_W'(WARM_LIMIT)) ? CNT_W'(WARM_LIMIT) : sum[CNT_W-1:0];
        limit     = cold_start ? SUM_W'(COLD_LIMIT) : SUM_W'(WARM_LIMIT);
        limit_hit = !clear && !freeze && (n_evt != '0) && (sum >= limit);
        win_last  = (win_cnt == WIN_W'(WINDOW_TICKS - 1));
    end

    // Count and window state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fault_cnt <= '0;
            win_cnt   <= '0;
        end else if (!freeze) begin
            if (n_evt != '0) begin
                fault_cnt <= cnt_sat;
                win_cnt   <= '0;
            end else if (tick && (fault_cnt != '0)) begin
                if (win_last) begin
                    fault_cnt <= '0;
                    win_cnt   <= '0;
                end else begin
                    win_cnt <= win_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fsup_shutdown_latch.sv
// Global shutdown latch.
// Set by overvoltage, over-temperature or the count limit. Released by a
// deepest-sleep rising edge, and for a thermal cause only if the cool flag
// is high at that edge. Any set condition outranks release.
module fsup_shutdown_latch
    import fsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_any,
    input  logic ot_hot,
    input  logic ot_cool,
    input  logic limit_hit,
    input  logic s5_rise,
    output logic shutdown
);

    sd_cause_e cause;

    // Latch state and the cause that governs its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
            cause    <= CAUSE_NONE;
        end else if (ot_hot) begin
            shutdown <= 1'b1;
            cause    <= CAUSE_THERMAL;
        end else if (ov_any) begin
            shutdown <= 1'b1;
            if (cause != CAUSE_THERMAL) begin
                cause <= CAUSE_OVERVOLT;
            end
        end else if (limit_hit) begin
            shutdown <= 1'b1;
            cause    <= CAUSE_LIMIT;
        end else if (s5_rise && shutdown && ((cause != CAUSE_THERMAL) || ot_cool)) begin
            shutdown <= 1'b0;
            cause    <= CAUSE_NONE;
        end
    end

endmodule

// File: rtl/fault_supervisor.sv
// Power-rail fault supervisor, top level.
// Qualifies fault flags into events and holds one disable bit per rail. It
// feeds the count and window and drives the shutdown latch. A rising edge
// on s5_n clears the count and the disables and may release the latch.
// Assumes all inputs are synchronous to clk and tick is a one-cycle enable.
module fault_supervisor #(
    parameter int N_RAILS      = 4,
    parameter int WINDOW_TICKS = 16384,
    parameter int COLD_LIMIT   = 4,
    parameter int WARM_LIMIT   = 5,
    localparam int CNT_W       = $clog2(WARM_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               s5_n,
    input  logic               cold_start,
    input  logic [N_RAILS-1:0] rail_en,
    input  logic [N_RAILS-1:0] rail_ss,
    input  logic [N_RAILS-1:0] uv,
    input  logic               oc_vddq,
    input  logic               ov_vddq,
    input  logic               ov_term,
    input  logic               ot_hot,
    input  logic               ot_cool,
    input  logic [N_RAILS-1:0] retry_start,
    output logic [N_RAILS-1:0] rail_dis,
    output logic               shutdown,
    output logic [CNT_W-1:0]   fault_cnt
);

    logic               s5_q;
    logic               s5_rise;
    logic [N_RAILS-1:0] rail_evt;
    logic [N_RAILS-1:0] evt_live;
    logic               limit_hit;

    // Track the sleep input for rising-edge detection; held high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s5_q <= 1'b1;
        end else begin
            s5_q <= s5_n;
        end
    end

    // Sleep release edge, and events gated by the shutdown latch.
    always_comb begin
        s5_rise  = s5_n & ~s5_q;
        evt_live = rail_evt & ~{N_RAILS{shutdown}};
    end

    fsup_event_qual #(
        .N_RAILS (N_RAILS)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .uv       (uv),
        .rail_en  (rail_en),
        .rail_ss  (rail_ss),
        .rail_dis (rail_dis),
        .oc_vddq  (oc_vddq),
        .rail_evt (rail_evt)
    );

    fsup_fault_window #(
        .N_RAILS      (N_RAILS),
        .WINDOW_TICKS (WINDOW_TICKS),
        .COLD_LIMIT   (COLD_LIMIT),
        .WARM_LIMIT   (WARM_LIMIT)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clear      (s5_rise),
        .freeze     (shutdown),
        .cold_start (cold_start),
        .evt        (evt_live),
        .fault_cnt  (fault_cnt),
        .limit_hit  (limit_hit)
    );

    fsup_shutdown_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ov_any    (ov_vddq | ov_term),
        .ot_hot    (ot_hot),
        .ot_cool   (ot_cool),
        .limit_hit (limit_hit),
        .s5_rise   (s5_rise),
        .shutdown  (shutdown)
    );

    for (genvar g = 0; g < N_RAILS; g++) begin : g_dis
        // Per-rail disable: sleep release clears, a fault sets, a retry clears.
        always_ff @(posedge clk) begin
            if (!rst_n || s5_rise) begin
                rail_dis[g] <= 1'b0;
            end else if (evt_live[g]) begin
                rail_dis[g] <= 1'b1;
            end else if (retry_start[g]) begin
                rail_dis[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fsup_checker.sv
// Property checker for the fault supervisor, bound to every instance.
module fsup_checker #(
    parameter int N_RAILS    = 4,
    parameter int WARM_LIMIT = 5,
    localparam int CNT_W     = $clog2(WARM_LIMIT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s5_n,
    input logic [N_RAILS-1:0] uv,
    input logic               oc_vddq,
    input logic               ov_vddq,
    input logic               ov_term,
    input logic               ot_hot,
    input logic               ot_cool,
    input logic [N_RAILS-1:0] rail_en,
    input logic [N_RAILS-1:0] rail_ss,
    input logic [N_RAILS-1:0] retry_start,
    input logic [N_RAILS-1:0] rail_dis,
    input logic               shutdown,
    input logic [CNT_W-1:0]   fault_cnt
);

    a_r9_ov_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_vddq || ov_term) |=> shutdown);

    a_r8_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cnt <= CNT_W'(WARM_LIMIT));

    a_r8_warm_limit_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cnt == CNT_W'(WARM_LIMIT)) |-> shutdown);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !(s5_n && !$past(s5_n))) |=> $stable(fault_cnt));

    a_r11_s5_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s5_n) && ot_cool && !ot_hot && !ov_vddq && !ov_term)
        |=> (fault_cnt == '0 && !shutdown && rail_dis == '0));

    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail_chk
        a_r12_retry_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (retry_start[g] && !uv[g] && !(oc_vddq && (g == 0))) |=> !rail_dis[g]);

        a_r3_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!rail_dis[g] && (rail_ss[g] || !rail_en[g]) && !(oc_vddq && (g == 0)))
            |=> !rail_dis[g]);
    end

endmodule

bind fault_supervisor fsup_checker #(
    .N_RAILS    (N_RAILS),
    .WARM_LIMIT (WARM_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s5_n        (s5_n),
    .uv          (uv),
    .oc_vddq     (oc_vddq),
    .ov_vddq     (ov_vddq),
    .ov_term     (ov_term),
    .ot_hot      (ot_hot),
    .ot_cool     (ot_cool),
    .rail_en     (rail_en),
    .rail_ss     (rail_ss),
    .retry_start (retry_start),
    .rail_dis    (rail_dis),
    .shutdown    (shutdown),
    .fault_cnt   (fault_cnt)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       s5_n;
    logic       cold_start;
    logic [3:0] rail_en;
    logic [3:0] rail_ss;
    logic [3:0] uv;
    logic       oc_vddq;
    logic       ov_vddq;
    logic       ov_term;
    logic       ot_hot;
    logic       ot_cool;
    logic [3:0] retry_start;
    logic [3:0] rail_dis;
    logic       shutdown;
    logic [2:0] fault_cnt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Bench model of the expected outputs.
    logic [2:0] m_cnt;
    logic [3:0] m_dis;
    logic       m_sd;

    // Scoreboard queues.
    string      q_tag[$];
    logic [7:0] q_val[$];

    always #2.5 clk = ~clk;

    fault_supervisor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .s5_n        (s5_n),
        .cold_start  (cold_start),
        .rail_en     (rail_en),
        .rail_ss     (rail_ss),
        .uv          (uv),
        .oc_vddq     (oc_vddq),
        .ov_vddq     (ov_vddq),
        .ov_term     (ov_term),
        .ot_hot      (ot_hot),
        .ot_cool     (ot_cool),
        .retry_start (retry_start),
        .rail_dis    (rail_dis),
        .shutdown    (shutdown),
        .fault_cnt   (fault_cnt)
    );

    // Driver side: one clock edge, then queue the expected outputs of that edge.
    task automatic chk(input string tag);
        @(posedge clk);
        q_tag.push_back(tag);
        q_val.push_back({m_sd, m_dis, m_cnt});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic s5_cycle(input string tag, input bit clears);
        s5_n = 1'b0;
        chk({tag, " sleep low"});
        s5_n = 1'b1;
        m_cnt = '0;
        m_dis = '0;
        if (clears) m_sd = 1'b0;
        chk({tag, " sleep release"});
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Monitor: compare outputs against queued expectations away from the edge.
    always @(negedge clk) begin
        logic [7:0] e;
        string      t;
        while (q_val.size() > 0) begin
            e = q_val.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({shutdown, rail_dis, fault_cnt} !== e) begin
                failures++;
                $display("FAIL %s actual sd/dis/cnt=%b expected=%b", t,
                         {shutdown, rail_dis, fault_cnt}, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; s5_n = 1'b1; cold_start = 1'b0;
        rail_en = 4'b1111; rail_ss = '0; uv = '0; oc_vddq = 1'b0;
        ov_vddq = 1'b0; ov_term = 1'b0; ot_hot = 1'b0; ot_cool = 1'b1;
        retry_start = '0;
        m_cnt = '0; m_dis = '0; m_sd = 1'b0;

        idle(3);
        chk("R1 in reset");
        rst_n = 1'b1;
        chk("R1 after release");

        // R2: single qualified undervoltage edge
        uv[1] = 1'b1; m_cnt = 1; m_dis[1] = 1'b1;
        chk("R2 uv rail1");
        uv[1] = 1'b0;
        chk("R2 hold");

        // R4: held level counts once
        uv[2] = 1'b1; m_cnt = 2; m_dis[2] = 1'b1;
        chk("R4 rise rail2");
        chk("R4 held 1");
        chk("R4 held 2");
        uv[2] = 1'b0;
        chk("R4 drop");
        // R12: retry clears only its rail
        retry_start[2] = 1'b1; m_dis[2] = 1'b0;
        chk("R12 retry rail2");
        retry_start[2] = 1'b0;
        uv[2] = 1'b1; m_cnt = 3; m_dis[2] = 1'b1;
        chk("R4 second rise rail2");
        uv[2] = 1'b0;

        // R3: soft-start, disabled-by-sequencer and already-faulted rails ignored
        rail_ss[3] = 1'b1; uv[3] = 1'b1;
        chk("R3 soft-start rail3");
        uv[3] = 1'b0; rail_ss[3] = 1'b0; rail_en[3] = 1'b0;
        chk("R3 prep");
        uv[3] = 1'b1;
        chk("R3 rail3 not enabled");
        uv[3] = 1'b0; rail_en[3] = 1'b1;
        uv[1] = 1'b1;
        chk("R3 rail1 already disabled");
        uv[1] = 1'b0;

        // R11: sleep release clears count and disables
        s5_cycle("R11", 1'b1);

        // R7: window expiry exactly WINDOW_TICKS after the fault
        uv[0] = 1'b1; m_cnt = 1; m_dis[0] = 1'b1;
        chk("R7 fault rail0");
        uv[0] = 1'b0;
        idle(16382);
        chk("R7 one tick before expiry");
        m_cnt = 0;
        chk("R7 expiry clears");
        retry_start[0] = 1'b1; m_dis[0] = 1'b0;
        chk("R12 retry rail0");
        retry_start[0] = 1'b0;

        // R7: a new fault restarts the window
        uv[1] = 1'b1; m_cnt = 1; m_dis[1] = 1'b1;
        chk("R7 fault rail1");
        uv[1] = 1'b0;
        idle(10000);
        uv[2] = 1'b1; m_cnt = 2; m_dis[2] = 1'b1;
        chk("R7 restart fault rail2");
        uv[2] = 1'b0;
        idle(16382);
        chk("R7 restarted window held");
        m_cnt = 0;
        chk("R7 restarted window clears");

        // R7: fault on the expiring tick wins
        uv[3] = 1'b1; m_cnt = 1; m_dis[3] = 1'b1;
        chk("R7 fault rail3");
        uv[3] = 1'b0;
        idle(16382);
        chk("R7 pre-expiry");
        uv[0] = 1'b1; m_cnt = 2; m_dis[0] = 1'b1;
        chk("R7 fault on expiry tick");
        uv[0] = 1'b0;
        s5_cycle("R11 cleanup", 1'b1);

        // R6: cascaded faults in one cycle
        uv[2] = 1'b1; uv[3] = 1'b1; m_cnt = 2; m_dis = 4'b1100;
        chk("R6 two rails same cycle");
        uv = '0;

        // R5: overcurrent on rail 0
        oc_vddq = 1'b1; m_cnt = 3; m_dis[0] = 1'b1;
        chk("R5 overcurrent rail0");
        oc_vddq = 1'b0;

        // R8: warm limit of five
        uv[1] = 1'b1; m_cnt = 4; m_dis[1] = 1'b1;
        chk("R8 warm count four no shutdown");
        uv[1] = 1'b0;
        retry_start[1] = 1'b1; m_dis[1] = 1'b0;
        chk("R12 retry rail1");
        retry_start[1] = 1'b0;
        uv[1] = 1'b1; m_cnt = 5; m_dis[1] = 1'b1; m_sd = 1'b1;
        chk("R8 warm limit shutdown");
        uv[1] = 1'b0;
        retry_start[1] = 1'b1; m_dis[1] = 1'b0;
        chk("R12 retry during shutdown");
        retry_start[1] = 1'b0;
        uv[1] = 1'b1;
        chk("R8 frozen while shut down");
        uv[1] = 1'b0;
        s5_cycle("R11 after limit", 1'b1);

        // R8: cold-start limit of four
        cold_start = 1'b1;
        uv[0] = 1'b1; m_cnt = 1; m_dis[0] = 1'b1; chk("R8 cold f1"); uv[0] = 1'b0;
        uv[1] = 1'b1; m_cnt = 2; m_dis[1] = 1'b1; chk("R8 cold f2"); uv[1] = 1'b0;
        uv[2] = 1'b1; m_cnt = 3; m_dis[2] = 1'b1; chk("R8 cold f3"); uv[2] = 1'b0;
        uv[3] = 1'b1; m_cnt = 4; m_dis[3] = 1'b1; m_sd = 1'b1;
        chk("R8 cold limit shutdown");
        uv[3] = 1'b0;
        s5_cycle("R11 after cold", 1'b1);
        cold_start = 1'b0;

        // R9: overvoltage shutdown and set-over-release priority
        ov_vddq = 1'b1; m_sd = 1'b1;
        chk("R9 ov rail0");
        ov_vddq = 1'b0;
        s5_cycle("R9 release", 1'b1);
        ov_term = 1'b1; m_sd = 1'b1;
        chk("R9 ov termination");
        s5_cycle("R9 ov held through release", 1'b0);
        ov_term = 1'b0;
        s5_cycle("R9 release after ov", 1'b1);

        // R10: thermal shutdown needs the cool flag to release
        ot_cool = 1'b0; ot_hot = 1'b1; m_sd = 1'b1;
        chk("R10 over-temperature");
        ot_hot = 1'b0;
        s5_cycle("R10 not cool", 1'b0);
        ot_cool = 1'b1;
        s5_cycle("R10 cool release", 1'b1);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule